// File: doc/BRIEF.md
# Interlocked Bus Read Master

This block sits on the processor side of a shared system bus and runs one read transfer each time local logic asks for it. On a start pulse it takes the supplied address. It puts that address on the bus together with a memory-request strobe and a read/write line set to read. One clock later it raises its own sync strobe, which tells the slave that the request lines are valid. It then waits for the slave's sync answer.

The slave's sync line is asynchronous to this block, so it first passes through a chain of synchronizer flops. When the synchronized answer arrives, the data bus is loaded into a read buffer on that same edge. The block then takes the request down in strict order: the sync strobe drops first, and the address and request lines drop one step later. Before it reports completion it waits for the slave to release its own sync line. A one-cycle done pulse marks the return to idle, and a new transfer may be started in that same cycle.

Top module: `bus_rd_master`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, the outputs are idle: bus_addr_o 0, bus_mreq_o 0, bus_rw_o 1, bus_msync_o 0, busy_o 0, done_o 0, rd_data_o 0.
- R2: When start_i is high at a clock edge while idle, the block samples addr_i on that edge. From that edge it drives bus_addr_o with that address, bus_mreq_o 1 and bus_rw_o 0 (0 = read, 1 = write), while bus_msync_o stays 0 for that first cycle.
- R3: bus_msync_o rises exactly one cycle after bus_mreq_o rises, and only while bus_mreq_o was already high in the cycle before.
- R4: While bus_msync_o is high, bus_mreq_o is 1, bus_rw_o is 0 and bus_addr_o does not change.
- R5: bus_ssync_i passes through SYNC_STAGES flops, default 2. If bus_ssync_i first goes high between edge L and edge L+1 counted from the start edge, rd_data_o takes bus_data_i at edge L+3. It holds that value until the next capture.
- R6: bus_msync_o falls one cycle after the capture edge. bus_mreq_o falls and bus_addr_o returns to 0 one cycle after that, never in the same cycle as bus_msync_o.
- R7: After the request is withdrawn, the block waits for the synchronized slave sync to read low. It then returns to idle with done_o high for exactly one cycle. If the slave drops bus_ssync_i between edges L+3+M and L+4+M, done_o is first high after edge max(L+7, L+6+M).
- R8: A start_i pulse while busy_o is high is ignored: the address on the bus and the completion count do not change.
- R9: busy_o is high from the first request cycle until the return to idle. It is low in the cycle done_o is high.
- R10: A start_i that is high in the same cycle as done_o begins a new transfer at the next edge, with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one read transfer |
| addr_i | input | ADDR_W | Address for the requested read |
| bus_addr_o | output | ADDR_W | Address lines to the bus, 0 when idle |
| bus_mreq_o | output | 1 | Memory-request strobe |
| bus_rw_o | output | 1 | Read/write line, 0 = read, 1 when idle |
| bus_msync_o | output | 1 | Master sync strobe: request lines valid |
| bus_ssync_i | input | 1 | Slave sync answer, asynchronous |
| bus_data_i | input | DATA_W | Data bus from the slave |
| rd_data_o | output | DATA_W | Read buffer holding the last captured data |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse on return to idle |

## Verification
The one place where two functions meet in a single cycle is the done cycle. There the block finishes one transfer and may accept the next start_i. The bench provokes this by raising start_i in the same cycle it first sees done_o. It then requires the request lines of the new address one edge later, with the same rising order as any other transfer. A second overlap exists: a stray start_i arriving mid-transfer falls on a cycle where the state machine is busy with its own steps. The bench pulses start_i with a different address in the wait phase. It judges that neither the bus address nor the completion time moves. All of this runs over a full sweep of slave raise and release delays, where the completion cycle is computed from the delays.

// File: rtl/brm_pkg.sv
package brm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DRIVE_REQ = 3'd1,
        ST_RAISE_SYN = 3'd2,
        ST_WAIT_ACK  = 3'd3,
        ST_CAPTURE   = 3'd4,
        ST_DROP_SYN  = 3'd5,
        ST_DROP_REQ  = 3'd6,
        ST_WAIT_REL  = 3'd7
    } brm_state_e;

    typedef struct packed {
        logic mreq;
        logic rw;
        logic msync;
    } brm_ctl_t;

    // Bus control lines held in each state; rw is 0 (read) only while requesting.
    function automatic brm_ctl_t brm_decode(input brm_state_e st);
        brm_ctl_t c;
        c.mreq  = 1'b0;
        c.rw    = 1'b1;
        c.msync = 1'b0;
        case (st)
            ST_DRIVE_REQ, ST_DROP_SYN: begin
                c.mreq = 1'b1;
                c.rw   = 1'b0;
            end
            ST_RAISE_SYN, ST_WAIT_ACK, ST_CAPTURE: begin
                c.mreq  = 1'b1;
                c.rw    = 1'b0;
                c.msync = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/brm_sync.sv
module brm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh_q;
    logic [LAST:0] sh_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[LAST-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[LAST];
endmodule

// File: rtl/brm_capture.sv
module brm_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] buf_d;
    logic [DATA_W-1:0] buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load_i) buf_d = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign data_o = buf_q;
endmodule

// File: rtl/brm_seq.sv
module brm_seq
    import brm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ack_s_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              mreq_o,
    output logic              rw_o,
    output logic              msync_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cap_load_o
);
    typedef struct packed {
        brm_state_e        st;
        logic [ADDR_W-1:0] addr;
        brm_ctl_t          ctl;
        logic              busy;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d;
    seq_regs_t r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_DRIVE_REQ;
                    r_d.addr = addr_i;
                end
            end
            ST_DRIVE_REQ: r_d.st = ST_RAISE_SYN;
            ST_RAISE_SYN: r_d.st = ST_WAIT_ACK;
            ST_WAIT_ACK:  if (ack_s_i) r_d.st = ST_CAPTURE;
            ST_CAPTURE:   r_d.st = ST_DROP_SYN;
            ST_DROP_SYN:  r_d.st = ST_DROP_REQ;
            ST_DROP_REQ:  r_d.st = ST_WAIT_REL;
            ST_WAIT_REL: begin
                if (!ack_s_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.ctl  = brm_decode(r_d.st);
        r_d.busy = (r_d.st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.addr <= '0;
            r_q.ctl  <= brm_decode(ST_IDLE);
            r_q.busy <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_addr_o = r_q.ctl.mreq ? r_q.addr : '0;
    assign mreq_o     = r_q.ctl.mreq;
    assign rw_o       = r_q.ctl.rw;
    assign msync_o    = r_q.ctl.msync;
    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign cap_load_o = (r_q.st == ST_WAIT_ACK) && ack_s_i;
endmodule

// File: rtl/bus_rd_master.sv
module bus_rd_master #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_mreq_o,
    output logic              bus_rw_o,
    output logic              bus_msync_o,
    input  logic              bus_ssync_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              done_o
);
    logic ack_s;
    logic cap_load;

    brm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_ssync_i),
        .q_o   (ack_s)
    );

    brm_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .ack_s_i    (ack_s),
        .bus_addr_o (bus_addr_o),
        .mreq_o     (bus_mreq_o),
        .rw_o       (bus_rw_o),
        .msync_o    (bus_msync_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .cap_load_o (cap_load)
    );

    brm_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cap_load),
        .data_i (bus_data_i),
        .data_o (rd_data_o)
    );
endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_mreq_o,
    input logic              bus_rw_o,
    input logic              bus_msync_o,
    input logic              busy_o,
    input logic              done_o
);
    p_sync_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_msync_o |-> (bus_mreq_o && !bus_rw_o));

    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_msync_o && $past(bus_msync_o)) |-> $stable(bus_addr_o));

    p_sync_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_msync_o) |-> $past(bus_mreq_o));

    p_sync_drops_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_mreq_o) |-> !$past(bus_msync_o));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_req_means_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mreq_o |-> busy_o);
endmodule

bind bus_rd_master brm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_o  (bus_addr_o),
    .bus_mreq_o  (bus_mreq_o),
    .bus_rw_o    (bus_rw_o),
    .bus_msync_o (bus_msync_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/sim_bus_rd_master.sv
module sim_bus_rd_master;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] b_addr;
    logic          b_mreq, b_rw, b_msync;
    logic          b_ssync = 1'b0;
    logic [DW-1:0] b_data = '0;
    logic [DW-1:0] rd_data;
    logic          busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int lat_up = 1;
    int lat_dn = 1;
    logic [AW-1:0] cur_addr = '0;

    always #5 clk = ~clk;

    bus_rd_master u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .bus_addr_o(b_addr), .bus_mreq_o(b_mreq), .bus_rw_o(b_rw),
        .bus_msync_o(b_msync), .bus_ssync_i(b_ssync), .bus_data_i(b_data),
        .rd_data_o(rd_data), .busy_o(busy), .done_o(done)
    );

    function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a);
        return DW'(a * 3 + 16'h1234);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave model: raises sync after lat_up cycles of master sync, releases after lat_dn cycles without it.
    int up_cnt = 0;
    int dn_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            b_ssync <= 1'b0; up_cnt <= 0; dn_cnt <= 0;
        end else if (b_msync && !b_ssync) begin
            if (up_cnt + 1 >= lat_up) begin
                b_ssync <= 1'b1;
                b_data  <= slave_word(b_addr);
                up_cnt  <= 0;
            end else up_cnt <= up_cnt + 1;
        end else if (!b_msync && b_ssync) begin
            if (dn_cnt + 1 >= lat_dn) begin
                b_ssync <= 1'b0;
                b_data  <= 16'hDEAD ^ b_addr;
                dn_cnt  <= 0;
            end else dn_cnt <= dn_cnt + 1;
        end else if (!b_ssync) begin
            b_data <= 16'hDEAD ^ b_addr;
        end
    end

    // Ordering monitor
    logic p_msync = 1'b0, p_mreq = 1'b0, p_rw = 1'b1;
    logic [AW-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_msync && b_msync) begin
                check("R4 addr stable", {16'd0, b_addr}, {16'd0, p_addr});
                check("R4 mreq/rw held", {30'd0, b_mreq, b_rw}, {30'd0, 2'b10});
            end
            if (p_mreq && !b_mreq)
                check("R6 sync dropped before request", {31'd0, p_msync}, 32'd0);
            if (!p_msync && b_msync)
                check("R3 sync after request", {31'd0, p_mreq}, 32'd1);
        end
        p_msync = b_msync; p_mreq = b_mreq; p_rw = b_rw; p_addr = b_addr;
    end

    task automatic run_txn(input logic [AW-1:0] a, input int up, input int dn,
                           input bit immediate, input bit stray);
        int cnt = 0;
        int expk;
        lat_up = up; lat_dn = dn;
        if (!immediate) @(negedge clk);
        start = 1'b1; addr = a; cur_addr = a;
        expk = (up + 7 > up + 6 + dn) ? up + 7 : up + 6 + dn;
        forever begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                start = 1'b0;
                check(immediate ? "R10 back-to-back request" : "R2 request lines",
                      {b_addr, 13'd0, b_mreq, b_rw, b_msync}, {a, 13'd0, 3'b100});
                check("R9 busy", {31'd0, busy}, 32'd1);
            end
            if (cnt == 2) check("R3 sync one cycle later", {31'd0, b_msync}, 32'd1);
            if (stray && cnt == 4) begin start = 1'b1; addr = ~a; end
            if (stray && cnt == 5) begin
                start = 1'b0;
                check("R8 stray start ignored", {16'd0, b_addr}, {16'd0, a});
            end
            if (done || cnt > 80) break;
        end
        check("R7 completion cycle", cnt, expk + 1);
        check("R5 captured data", {16'd0, rd_data}, {16'd0, slave_word(a)});
        check("R9 busy low at done", {31'd0, busy}, 32'd0);
        check("R6 lines released", {b_addr, 13'd0, b_mreq, b_rw, b_msync}, {16'd0, 13'd0, 3'b010});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {b_addr, rd_data}, 32'd0);
        check("R1 reset controls", {27'd0, b_mreq, b_rw, b_msync, busy, done}, {27'd0, 5'b01000});
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {27'd0, b_mreq, b_rw, b_msync, busy, done}, {27'd0, 5'b01000});
        for (int up = 1; up <= 4; up++)
            for (int dn = 1; dn <= 4; dn++)
                run_txn(AW'(16'h0100 * up + 16'h0011 * dn), up, dn, 1'b0, (up + dn) % 2 == 0);
        run_txn(16'hFFFF, 2, 3, 1'b0, 1'b0);
        run_txn(16'h0000, 3, 1, 1'b1, 1'b0);
        run_txn(16'hA5A5, 1, 4, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 buffer holds", {16'd0, rd_data}, {16'd0, slave_word(16'hA5A5)});
        check("R7 single done pulse", {31'd0, done}, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule